// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a singly linked list of command blocks held in a 2 MB system memory and streams the payload of each block, one 32-bit word at a time, to a downstream command packetizer. Every node opens with a header word. Its top byte holds how many payload words follow the header. Its low 24 bits hold the byte address of the next node. The payload words sit at the word addresses directly after the header.

A malformed list may point back into itself. To guard against this, the walker writes bit 23 into every header it visits before it forwards that node's payload. Reaching a header whose next-address field already carries bit 23 ends the walk after that node. When the walk is over, a second pass starts again from the start address. It revisits exactly as many nodes as the first pass touched and clears bit 23 in each of their headers. A one-cycle done pulse then reports completion. Memory arbitration sits outside the block. The block sees one read port with a split request/response, and one write port that accepts a write in the cycle it is issued.

Top module: `dma_chain_walker`

## Requirements
- R1: While reset is asserted and directly after it, busy, done, rdReq, wrEn and outValid are all low.
- R2: Header bits 31:24 give the payload word count and bits 23:0 give the next node's byte address. Only bits 20:2 of a node address form the 19-bit word index, so bits 22:21 are ignored. The payload words are read from the consecutive word indices that follow the header and are forwarded in that order.
- R3: The start address is 24 bits wide. A start address of 0xFFFFFF makes no memory access at all and still produces a done pulse.
- R4: Each visited header is written back to its own word index with bit 23 set, and this happens before any payload word of that visit is forwarded.
- R5: If the header just read already has bit 23 set, the walk stops after that node's payload has been forwarded. A revisited node therefore has its payload sent a second time.
- R6: A node whose count is zero forwards no payload word, and the walk still moves on to its next address.
- R7: When the next address equals 0xFFFFFF, the first pass ends.
- R8: The cleanup pass starts at the start address and follows the stored headers. It makes one header write per node visited in the first pass and clears bit 23 in each. After done, memory matches its initial contents except that bit 23 is clear in every visited header.
- R9: A payload word is offered with outValid and transferred on a cycle where outReady is high. While outValid is high and outReady is low, outValid stays high and outData is held.
- R10: busy rises in the cycle after start is accepted and stays high through both passes. done is a single-cycle pulse with busy low, issued after the last cleanup write.
- R11: At most one read is outstanding, a read request never lasts more than one cycle in a row, rdReq and wrEn are never high together, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| startAddr | input | 24 | Byte address of the first node |
| busy | output | 1 | Walk or cleanup in progress |
| done | output | 1 | One-cycle pulse after cleanup |
| rdReq | output | 1 | Read request strobe |
| rdAddr | output | 19 | Word index of the read |
| rdValid | input | 1 | Read response valid |
| rdData | input | 32 | Read response data |
| wrEn | output | 1 | Header write strobe |
| wrAddr | output | 19 | Word index of the write |
| wrData | output | 32 | Header value written |
| outValid | output | 1 | Payload word available |
| outData | output | 32 | Payload word |
| outReady | input | 1 | Downstream accepts the word |

## Verification
The properties assume that memory answers every read request with exactly one rdValid pulse, at least one cycle later and never unprompted, and that a write is taken in the cycle wrEn is high. The bench's memory responder keeps to this. It registers each request at the falling edge and returns data after a random delay of one to three cycles. It also applies every write at once, so a revisited header shows its marker. The outReady line is toggled at random, which exercises the hold-while-stalled rule. Node lists are laid out in non-overlapping slots so that no payload covers another node's header.

// File: rtl/chain_walk_pkg.sv
package chain_walk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HREQ,
    ST_HWAIT,
    ST_MARK,
    ST_PREQ,
    ST_PWAIT,
    ST_PUSH,
    ST_NEXT,
    ST_CCHECK,
    ST_CREQ,
    ST_CWAIT,
    ST_CWRITE,
    ST_DONE
  } walkState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadStart;
    logic loadHeader;
    logic captureWord;
    logic advPayload;
    logic followNext;
    logic rewind;
    logic incCount;
    logic decCount;
    logic selPayload;
    logic setMark;
  } walkStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic atEnd;
    logic lenZero;
    logic lastWord;
    logic stopHit;
    logic cntZero;
  } walkStatus_t;

endpackage

// File: rtl/chain_walk_dp.sv
module chain_walk_dp
  import chain_walk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 21,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  localparam int IDX_W = MEM_AW - 2,
  localparam int CNT_W = MEM_AW - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] rdData,
  output walkStatus_t       stat,
  output logic [IDX_W-1:0]  rdAddr,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] outData
);

  localparam int MARK_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] END_ADDR = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] MARK_MASK = DATA_W'(1) << MARK_BIT;

  logic [ADDR_W-1:0] startReg;
  logic [ADDR_W-1:0] nodeAddr;
  logic [DATA_W-1:0] hdr;
  logic [IDX_W-1:0]  ptr;
  logic [LEN_W-1:0]  remain;
  logic [CNT_W-1:0]  visitCnt;
  logic [DATA_W-1:0] word;
  logic [IDX_W-1:0]  nodeIdx;

  assign nodeIdx = nodeAddr[MEM_AW-1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      nodeAddr <= '0;
      hdr      <= '0;
      ptr      <= '0;
      remain   <= '0;
      visitCnt <= '0;
      word     <= '0;
    end else begin
      if (strb.loadStart) begin
        startReg <= startAddr;
        nodeAddr <= startAddr;
        visitCnt <= '0;
      end
      if (strb.loadHeader) begin
        hdr    <= rdData;
        ptr    <= nodeIdx + IDX_W'(1);
        remain <= rdData[DATA_W-1 -: LEN_W];
      end
      if (strb.captureWord) word <= rdData;
      if (strb.advPayload) begin
        ptr    <= ptr + IDX_W'(1);
        remain <= remain - LEN_W'(1);
      end
      if (strb.followNext) nodeAddr <= hdr[ADDR_W-1:0];
      if (strb.rewind)     nodeAddr <= startReg;
      if (strb.incCount)   visitCnt <= visitCnt + CNT_W'(1);
      if (strb.decCount)   visitCnt <= visitCnt - CNT_W'(1);
    end
  end

  always_comb begin
    stat.atEnd    = (nodeAddr == END_ADDR);
    stat.lenZero  = (hdr[DATA_W-1 -: LEN_W] == '0);
    stat.lastWord = (remain == LEN_W'(1));
    stat.stopHit  = hdr[MARK_BIT];
    stat.cntZero  = (visitCnt == '0);
  end

  assign rdAddr  = strb.selPayload ? ptr : nodeIdx;
  assign wrAddr  = nodeIdx;
  assign wrData  = strb.setMark ? (hdr | MARK_MASK) : (hdr & ~MARK_MASK);
  assign outData = word;

endmodule

// File: rtl/chain_walk_ctrl.sv
module chain_walk_ctrl
  import chain_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdValid,
  input  logic        outReady,
  input  walkStatus_t stat,
  output walkStrobe_t strb,
  output logic        rdReq,
  output logic        wrEn,
  output logic        outValid,
  output logic        busy,
  output logic        done
);

  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    rdReq     = 1'b0;
    wrEn      = 1'b0;
    outValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadStart = 1'b1;
          nextState      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (stat.atEnd) begin
          strb.rewind = 1'b1;
          nextState   = ST_CCHECK;
        end else begin
          nextState = ST_HREQ;
        end
      end
      ST_HREQ: begin
        rdReq     = 1'b1;
        nextState = ST_HWAIT;
      end
      ST_HWAIT: begin
        if (rdValid) begin
          strb.loadHeader = 1'b1;
          nextState       = ST_MARK;
        end
      end
      ST_MARK: begin
        wrEn          = 1'b1;
        strb.setMark  = 1'b1;
        strb.incCount = 1'b1;
        nextState     = stat.lenZero ? ST_NEXT : ST_PREQ;
      end
      ST_PREQ: begin
        rdReq           = 1'b1;
        strb.selPayload = 1'b1;
        nextState       = ST_PWAIT;
      end
      ST_PWAIT: begin
        if (rdValid) begin
          strb.captureWord = 1'b1;
          nextState        = ST_PUSH;
        end
      end
      ST_PUSH: begin
        outValid = 1'b1;
        if (outReady) begin
          strb.advPayload = 1'b1;
          nextState       = stat.lastWord ? ST_NEXT : ST_PREQ;
        end
      end
      ST_NEXT: begin
        if (stat.stopHit) begin
          strb.rewind = 1'b1;
          nextState   = ST_CCHECK;
        end else begin
          strb.followNext = 1'b1;
          nextState       = ST_CHECK;
        end
      end
      ST_CCHECK: begin
        nextState = stat.cntZero ? ST_DONE : ST_CREQ;
      end
      ST_CREQ: begin
        rdReq     = 1'b1;
        nextState = ST_CWAIT;
      end
      ST_CWAIT: begin
        if (rdValid) begin
          strb.loadHeader = 1'b1;
          nextState       = ST_CWRITE;
        end
      end
      ST_CWRITE: begin
        wrEn            = 1'b1;
        strb.decCount   = 1'b1;
        strb.followNext = 1'b1;
        nextState       = ST_CCHECK;
      end
      ST_DONE: begin
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
  import chain_walk_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 21,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  localparam int IDX_W = MEM_AW - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              busy,
  output logic              done,
  output logic              rdReq,
  output logic [IDX_W-1:0]  rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);

  walkStrobe_t strb;
  walkStatus_t stat;

  chain_walk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rdValid  (rdValid),
    .outReady (outReady),
    .stat     (stat),
    .strb     (strb),
    .rdReq    (rdReq),
    .wrEn     (wrEn),
    .outValid (outValid),
    .busy     (busy),
    .done     (done)
  );

  chain_walk_dp #(
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .startAddr (startAddr),
    .rdData    (rdData),
    .stat      (stat),
    .rdAddr    (rdAddr),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .outData   (outData)
  );

endmodule

// File: rtl/dma_chain_walker_chk.sv
module dma_chain_walker_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rdReq,
  input logic              wrEn,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

  // R11
  one_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R11
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrEn));

  // R9
  out_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

endmodule

bind dma_chain_walker dma_chain_walker_chk u_chk (.*);

// File: tb/dma_chain_walker_bench.sv
module dma_chain_walker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] startAddr = '0;
  logic        busy, done, rdReq, wrEn, outValid;
  logic [18:0] rdAddr, wrAddr;
  logic [31:0] wrData, outData;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic        outReady = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dma_chain_walker u_dma_chain_walker (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .busy(busy), .done(done), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;

  logic [31:0] mem   [logic [18:0]];
  logic [31:0] snap  [logic [18:0]];
  logic [31:0] expMem[logic [18:0]];

  logic [18:0] wrA[$];
  logic [31:0] wrD[$];
  logic [31:0] gotW[$];
  int          gotWr[$];
  logic [31:0] expW[$];
  int          expV[$];
  logic [18:0] expH[$];
  int visits, doneCnt, rdCnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] rdOf(input logic [18:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // independent reference walk over a copy of memory
  function automatic void model(input logic [23:0] sa);
    logic [23:0] a;
    logic [31:0] h;
    logic [18:0] idx;
    logic [31:0] sh[logic [18:0]];
    sh = mem;
    expW.delete(); expV.delete(); expH.delete();
    visits = 0;
    a = sa;
    while (a != 24'hFFFFFF && visits < 1000) begin
      idx = a[20:2];
      h = sh.exists(idx) ? sh[idx] : 32'h0;
      sh[idx] = h | 32'h0080_0000;
      expH.push_back(idx);
      for (int i = 0; i < int'(h[31:24]); i++) begin
        logic [18:0] p;
        p = idx + 19'(1 + i);
        expW.push_back(sh.exists(p) ? sh[p] : 32'h0);
        expV.push_back(visits);
      end
      visits++;
      a = h[23:0];
      if (h[23]) break;
    end
    expMem = mem;
    foreach (expH[i]) expMem[expH[i]] = rdOf(expH[i]) & ~32'h0080_0000;
  endfunction

  // memory responder, output sink and watchdog
  logic        pend = 1'b0;
  logic [18:0] pA;
  int          dly;
  logic        stallPrev = 1'b0;
  logic [31:0] stallData;
  initial begin
    forever begin
      @(negedge clk);
      cycle++;
      if (cycle > 150000) begin
        chk(1'b0, "R10", "watchdog expired", cycle, 150000);
        finishRun();
      end
      if (wrEn) begin
        mem[wrAddr] = wrData;
        wrA.push_back(wrAddr);
        wrD.push_back(wrData);
      end
      if (rdValid) rdValid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rdValid = 1'b1;
          rdData  = rdOf(pA);
          pend    = 1'b0;
        end else dly--;
      end
      if (rdReq) begin
        if (pend) chk(1'b0, "R11", "second read outstanding", 1, 0);
        pend = 1'b1;
        pA   = rdAddr;
        dly  = $urandom_range(0, 2);
        rdCnt++;
      end
      if (stallPrev && outValid)
        chk(outData == stallData, "R9", "held word", outData, stallData);
      outReady = ($urandom_range(0, 9) < 7);
      if (outValid && outReady) begin
        gotW.push_back(outData);
        gotWr.push_back(wrA.size());
      end
      stallPrev = outValid && !outReady;
      stallData = outData;
      if (done) begin
        doneCnt++;
        chk(!busy, "R10", "busy at done", busy, 0);
      end
    end
  end

  task automatic runChain(input logic [23:0] sa, input bit poke);
    int t;
    snap = mem;
    model(sa);
    wrA.delete(); wrD.delete(); gotW.delete(); gotWr.delete();
    doneCnt = 0; rdCnt = 0;
    @(negedge clk); #1;
    start = 1'b1; startAddr = sa;
    @(negedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      #1;
      start = 1'b1; startAddr = 24'h000400;
      @(negedge clk); #1;
      start = 1'b0;
    end
    t = 0;
    while (doneCnt == 0 && t < 20000) begin
      @(negedge clk); #1;
      t++;
    end
    chk(doneCnt == 1, "R10", "done pulses", doneCnt, 1);
    @(negedge clk); #1;
    chk(doneCnt == 1 && !busy, "R10", "single done then idle", doneCnt, 1);
    chk(gotW.size() == expW.size(), "R2", "payload count", gotW.size(), expW.size());
    foreach (expW[k]) if (k < gotW.size()) begin
      chk(gotW[k] == expW[k], "R2", "payload word", gotW[k], expW[k]);
      chk(gotWr[k] > expV[k], "R4", "marker before payload", gotWr[k], expV[k] + 1);
    end
    chk(wrA.size() == 2 * visits, "R8", "header writes", wrA.size(), 2 * visits);
    foreach (expH[i]) if (i < wrA.size()) begin
      chk(wrA[i] == expH[i] && wrD[i][23], "R4", "marker write addr", wrA[i], expH[i]);
    end
    foreach (expMem[a]) chk(rdOf(a) == expMem[a], "R8", "restored memory", rdOf(a), expMem[a]);
  endtask

  task automatic putNode(input logic [23:0] byteAddr, input int len,
                         input logic [23:0] nxt);
    logic [18:0] idx;
    idx = byteAddr[20:2];
    mem[idx] = {8'(len), nxt};
    for (int i = 0; i < len; i++) mem[idx + 19'(1 + i)] = $urandom();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk({busy, done, rdReq, wrEn, outValid} == 5'b0, "R1", "outputs in reset",
        {busy, done, rdReq, wrEn, outValid}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk({busy, done, rdReq, wrEn, outValid} == 5'b0, "R1", "outputs after reset",
        {busy, done, rdReq, wrEn, outValid}, 0);

    // R3 empty list
    mem.delete();
    runChain(24'hFFFFFF, 1'b0);
    chk(rdCnt == 0, "R3", "reads for end address", rdCnt, 0);

    // R6 zero-count node, R2 masked high bits, R7 terminator
    mem.delete();
    putNode(24'h000100, 2, 24'h000200);
    putNode(24'h000200, 0, 24'h600300);
    putNode(24'h000300, 3, 24'hFFFFFF);
    runChain(24'h000100, 1'b0);
    chk(visits == 3 && gotW.size() == 5, "R6", "zero node followed", gotW.size(), 5);

    // R5 loop A -> B -> A
    mem.delete();
    putNode(24'h001000, 1, 24'h002000);
    putNode(24'h002000, 2, 24'h001000);
    runChain(24'h001000, 1'b0);
    chk(visits == 3 && gotW.size() == 4, "R5", "revisit stops", gotW.size(), 4);
    if (gotW.size() == 4) chk(gotW[3] == gotW[0], "R5", "revisit payload", gotW[3], gotW[0]);

    // R11 start ignored while busy
    mem.delete();
    putNode(24'h000100, 3, 24'h000200);
    putNode(24'h000200, 2, 24'hFFFFFF);
    putNode(24'h000400, 4, 24'hFFFFFF);
    runChain(24'h000100, 1'b1);
    chk(gotW.size() == 5, "R11", "start while busy ignored", gotW.size(), 5);

    // random chains
    for (int r = 0; r < 25; r++) begin
      int k, base, j;
      logic [23:0] addrs[8];
      mem.delete();
      for (int s = 0; s < 64; s++) mem[19'h400 + 19'(s)] = $urandom();
      k = $urandom_range(1, 6);
      base = $urandom_range(0, 31);
      for (int i = 0; i < k; i++)
        addrs[i] = 24'((19'h400 + 19'(((base + i * 7) % 32) * 16)) * 4);
      for (int i = 0; i < k; i++) begin
        logic [23:0] nxt;
        if (i < k - 1) nxt = addrs[i + 1] | (24'($urandom_range(0, 3)) << 21);
        else if ($urandom_range(0, 1) == 0) nxt = 24'hFFFFFF;
        else begin
          j = $urandom_range(0, i);
          nxt = addrs[j];
        end
        putNode(addrs[i], $urandom_range(0, 6), nxt);
      end
      runChain(addrs[0], 1'b0);
    end

    finishRun();
  end

endmodule